// File: doc/BRIEF.md
# Two-Section Divide-by-Twelve Counter

This block is a 4-bit counter split into two independent sections, both clocked by one system clock. The first section is a single toggle stage. It advances on each falling edge of its count input `cp_a` and drives `q[0]`. The second section divides by six. It is built from a three-state stage that drives `q[2:1]` and a toggle stage that drives `q[3]`. It advances on each falling edge of its count input `cp_b`. Each count input passes through a synchronizer chain, and a falling-edge detector turns it into a single-cycle advance strobe.

The two sections are not connected inside the block. To get a divide-by-twelve, wire `q[0]` back to `cp_b` outside the block and feed the incoming pulses to `cp_a`. `q[3]` then becomes a square wave with equal high and low times, at one twelfth of the pulse rate. Used on its own, the second section gives divide-by-three at `q[1]` and `q[2]`, and divide-by-six at `q[3]`.

Two clear inputs form a gated clear. Only when both are high are all four outputs forced to zero, and counting is blocked for as long as they stay high.

Top module: `div12_counter`

## Requirements
- R1: Each falling edge of `cp_a` inverts `q[0]` once. Rising edges and steady levels leave `q[0]` unchanged.
- R2: Each falling edge of `cp_b` moves the code `{q[2],q[1]}` one step through 00 → 01 → 10 → 00, so each of these bits repeats every 3 edges. The code 11 never appears.
- R3: `q[3]` inverts exactly when `q[2]` goes from 1 to 0. Counting on `cp_b` therefore gives `q[3]` a period of 6 edges: 3 edges high and 3 edges low.
- R4: Edges on `cp_b` never change `q[0]`. Edges on `cp_a` never change `q[3:1]` unless `q[0]` is wired to `cp_b` outside the block.
- R5: While `clr_a` and `clr_b` are both high, `q` is 4'b0000 from the next clock on, and falling edges on either count input are ignored. The clear must be held for at least SYNC_STAGES+2 clocks.
- R6: Raising only one of `clr_a` or `clr_b` has no effect on `q` or on counting.
- R7: With `q[0]` wired to `cp_b`, `q[3]` repeats every 12 falling edges of `cp_a`, staying high for 6 and low for 6. The full output follows the count n as: `q[0]` = n mod 2, and m = (n/2) mod 6 sets `q[3]` = (m ≥ 3) and `{q[2],q[1]}` per R2 for m mod 3.
- R8: Suppose a count input is driven low between clock edges k-1 and k. The affected output changes at clock edge k+SYNC_STAGES, and not before. Each level must be held for at least SYNC_STAGES+1 clocks.
- R9: The synchronous system reset `rst` sets `q` to 4'b0000 at the next clock edge, including in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| cp_a | input | 1 | Count input of the divide-by-two section (falling edge counts) |
| cp_b | input | 1 | Count input of the divide-by-six section (falling edge counts) |
| clr_a | input | 1 | First clear input; acts only together with `clr_b` |
| clr_b | input | 1 | Second clear input; acts only together with `clr_a` |
| q | output | 4 | Counter outputs: `q[0]` from the first section, `q[3:1]` from the second |

## Verification
The first pattern pulses `cp_a` alone. It shows that `q[0]` toggles on falling edges only and that the second section stays still. The second pattern pulses `cp_b` alone through two full cycles. It separates the period-3 code on `q[2:1]` from the period-6 square wave on `q[3]`, and confirms that `q[0]` is untouched. The third pattern closes the `q[0]`-to-`cp_b` loop over 24 pulses. This reveals whether the divide-by-six section advances on the correct edge of `q[0]`, and it measures the 6-high/6-low duty at `q[3]`. Further runs use a single clear input, both clear inputs with pulses arriving during the clear, a mid-count system reset, and a cycle-exact probe of the edge-to-output latency.

// File: rtl/div12_pkg.sv
package div12_pkg;

    localparam int unsigned SYNC_STAGES_DEFAULT = 2;
    localparam int unsigned Q_WIDTH             = 4;

    typedef enum logic [1:0] {
        PH_ZERO = 2'b00,
        PH_ONE  = 2'b01,
        PH_TWO  = 2'b10
    } phase_e;

    typedef struct packed {
        logic   hi;
        logic   q2;
        logic   q1;
        logic   q0;
    } cnt_out_t;

    function automatic phase_e phase_next(input phase_e cur);
        case (cur)
            PH_ZERO: phase_next = PH_ONE;
            PH_ONE:  phase_next = PH_TWO;
            default: phase_next = PH_ZERO;
        endcase
    endfunction

    function automatic logic phase_wraps(input phase_e cur);
        phase_wraps = (cur == PH_TWO);
    endfunction

    function automatic cnt_out_t pack_out(input logic q0, input phase_e ph, input logic hi);
        cnt_out_t o;
        o.q0 = q0;
        o.q1 = ph[0];
        o.q2 = ph[1];
        o.hi = hi;
        pack_out = o;
    endfunction

endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= lvl;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign fall = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/half_stage.sv
module half_stage (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= 1'b0;
        else if (adv)   q <= ~q;
    end

    // R1 (q[0]) and R3 (q[3]): an advance strobe inverts the stage output
    p_toggle_on_adv_r1: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (q != $past(q)));

    // R5: clear wins over an advance
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == 1'b0));

endmodule

// File: rtl/third_stage.sv
module third_stage
    import div12_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   adv,
    output phase_e ph,
    output logic   wrap
);
    always_ff @(posedge clk) begin
        if (rst || clr) ph <= PH_ZERO;
        else if (adv)   ph <= phase_next(ph);
    end

    assign wrap = phase_wraps(ph);

    // R2: only the three legal codes ever appear
    p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
        ph != phase_e'(2'b11));

    // R2: one step per advance, in the fixed order
    p_step_order_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && $past(!rst)) |=> (ph == phase_next($past(ph))));

    // R2: no movement without an advance
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(ph));

endmodule

// File: rtl/div12_counter.sv
module div12_counter
    import div12_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cp_a,
    input  logic               cp_b,
    input  logic               clr_a,
    input  logic               clr_b,
    output logic [Q_WIDTH-1:0] q
);
    localparam int unsigned NUM_INPUTS = 2;
    localparam int unsigned IDX_A      = 0;
    localparam int unsigned IDX_B      = 1;

    logic [NUM_INPUTS-1:0] lvl;
    logic [NUM_INPUTS-1:0] fall;
    logic                  clr_both;
    logic                  q0_w;
    logic                  hi_w;
    logic                  wrap_w;
    phase_e                ph_w;
    cnt_out_t              out_s;

    assign lvl      = {cp_b, cp_a};
    assign clr_both = clr_a & clr_b;

    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_edge
            fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
                .clk  (clk),
                .rst  (rst),
                .lvl  (lvl[i]),
                .fall (fall[i])
            );
        end
    endgenerate

    half_stage u_sec_a (
        .clk (clk),
        .rst (rst),
        .clr (clr_both),
        .adv (fall[IDX_A]),
        .q   (q0_w)
    );

    third_stage u_sec_b_lo (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_both),
        .adv  (fall[IDX_B]),
        .ph   (ph_w),
        .wrap (wrap_w)
    );

    half_stage u_sec_b_hi (
        .clk (clk),
        .rst (rst),
        .clr (clr_both),
        .adv (fall[IDX_B] & wrap_w),
        .q   (hi_w)
    );

    assign out_s = pack_out(q0_w, ph_w, hi_w);
    assign q     = out_s;

    // R9: system reset empties the counter at the next edge
    p_sysreset_r9: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R5: gated clear empties all outputs
    p_gated_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr_both |=> (q == '0));

    // R3: q[3] inverts when q[2] drops
    p_hi_on_q2_fall_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(q[2]) && !$past(clr_both) && !$past(rst)) |-> (q[3] != $past(q[3])));

    // R4: the second section moves only on its own input
    p_sections_apart_r4: assert property (@(posedge clk) disable iff (rst)
        (!fall[IDX_B] && !clr_both) |=> $stable(q[3:1]));

    // R4: the first section moves only on its own input
    p_first_apart_r4: assert property (@(posedge clk) disable iff (rst)
        (!fall[IDX_A] && !clr_both) |=> $stable(q[0]));

endmodule

// File: tb/div12_counter_bench.sv
`timescale 1ns/1ps
module div12_counter_bench;

    localparam int unsigned SYNC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cp_a = 1'b0;
    logic       cp_b_drv = 1'b0;
    logic       chain = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       cp_b;
    logic [3:0] q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit m_q0 = 1'b0;
    int m6   = 0;

    logic [3:0] exp_q[$];
    string      exp_tag[$];
    event       ev_sample;

    always #2.5 clk = ~clk;

    assign cp_b = chain ? q[0] : cp_b_drv;

    div12_counter #(.SYNC_STAGES(SYNC)) u_div12_counter (
        .clk   (clk),
        .rst   (rst),
        .cp_a  (cp_a),
        .cp_b  (cp_b),
        .clr_a (clr_a),
        .clr_b (clr_b),
        .q     (q)
    );

    function automatic logic [3:0] model_q();
        int lo;
        lo = m6 % 3;
        model_q = {(m6 >= 3), (lo == 2), (lo == 1), m_q0};
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: q actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_now(input string tag);
        exp_q.push_back(model_q());
        exp_tag.push_back(tag);
        -> ev_sample;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(ev_sample);
            @(negedge clk);
            while (exp_q.size() > 0) begin
                check(exp_tag.pop_front(), q, exp_q.pop_front());
            end
        end
    end

    task automatic pulse_a(input string tag);
        bit old;
        cp_a = 1'b1;
        repeat (6) @(negedge clk);
        cp_a = 1'b0;
        repeat (14) @(negedge clk);
        old  = m_q0;
        m_q0 = ~m_q0;
        if (chain && old && !m_q0) m6 = (m6 + 1) % 6;
        expect_now(tag);
    endtask

    task automatic pulse_b(input string tag, input bit counts);
        cp_b_drv = 1'b1;
        repeat (6) @(negedge clk);
        cp_b_drv = 1'b0;
        repeat (10) @(negedge clk);
        if (counts) m6 = (m6 + 1) % 6;
        expect_now(tag);
    endtask

    task automatic do_clear(input bit a, input bit b, input bit pulse_inside, input string tag);
        clr_a = a;
        clr_b = b;
        repeat (6) @(negedge clk);
        if (a && b) begin
            m_q0 = 1'b0;
            m6   = 0;
        end
        if (pulse_inside) pulse_b(tag, !(a && b));
        clr_a = 1'b0;
        clr_b = 1'b0;
        repeat (6) @(negedge clk);
        expect_now(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int highs;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset state", q, 4'b0000);

        // R1: first section alone, and R4: second section untouched
        for (int i = 0; i < 4; i++) pulse_a("R1/R4 cp_a alone");

        // R2, R3, R4: second section alone over two full cycles
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            pulse_b("R2/R3/R4 cp_b alone", 1'b1);
            if (m6 >= 3) highs++;
        end
        check("R3 q3 high count over 12 edges", 4'(highs), 4'd6);

        // R6: single clear inputs do nothing
        pulse_b("R2 setup", 1'b1);
        do_clear(1'b1, 1'b0, 1'b1, "R6 clr_a only");
        do_clear(1'b0, 1'b1, 1'b0, "R6 clr_b only");

        // R5: both clears, pulses during clear ignored
        pulse_a("R1 setup");
        do_clear(1'b1, 1'b1, 1'b1, "R5 gated clear");

        // R8: latency of the edge path
        cp_a = 1'b1;
        repeat (6) @(negedge clk);
        cp_a = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        check("R8 no change before latency", q, 4'b0000);
        @(posedge clk);
        @(negedge clk);
        check("R8 change at latency", q, 4'b0001);
        m_q0 = 1'b1;
        repeat (8) @(negedge clk);
        do_clear(1'b1, 1'b1, 1'b0, "R5 clear before chain");

        // R7: chained mode over 24 pulses
        chain = 1'b1;
        repeat (4) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 24; i++) begin
            pulse_a("R7 chained");
            if (m6 >= 3) highs++;
        end
        check("R7 q3 high count over 24 pulses", 4'(highs / 2), 4'd6);
        check("R7 back to zero after 12+12", q, 4'b0000);

        // R9: reset in the middle of a count
        for (int i = 0; i < 7; i++) pulse_a("R7 chained prefix");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid-count reset", q, 4'b0000);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule